// File: doc/BRIEF.md
# Parallel-Lane Spectrum Capture Buffer

This block takes one integrated power spectrum that leaves the upstream engine as four 32-bit lanes per clock and places it in a single dual-port memory. Once the spectrum is stored, a host that walks the addresses upward sees the channels in natural order. At input cycle `t` after the frame sync, lane `k` carries channel `4t+k`. A frame therefore spans 512 valid cycles for the default 2048 channels.

The layout is picked at elaboration. The serial layout delays lane `k` by `k` frame lengths, using chained 512-deep ring delay stages, and then multiplexes the lanes into one 32-bit write stream. That stream needs four frames of valid cycles to store one spectrum. The wide layout concatenates the four lanes into one 128-bit row per input cycle, giving 512 rows. On the host side a 32-bit read port with an 11-bit word address serves both layouts. Its latency is one cycle plus zero, one or two optional pipeline stages.

The host uses an arm pulse and a done flag to control capture. After arming, the next sync starts a capture. The done flag rises once the last channel has been written, and no further writes happen until the next arm. A sync that lands inside a frame during a capture aborts that capture and sets a sticky error flag.

Top module: `spectrum_capture_buf`

## Requirements
- R1: While `rst_n` is low at a clock edge, `done`, `err` and `rd_valid` read 0 after that edge.
- R2: Serial layout (`WIDE_MODE`=0): after a capture, host word address N returns channel N of the captured frame, for every N in 0..2047. Channel N is the word on lane N mod 4 at valid cycle N/4 of the frame.
- R3: Wide layout (`WIDE_MODE`=1): row t holds lane k in bits [32k+31:32k]. Host address N selects row N[10:2] and slice N[1:0], so address N returns channel N.
- R4: A read request (`rd_en` high) shows its data with `rd_valid` high exactly 1+`READ_PIPE` clock edges later.
- R5: After an arm, the first cycle with both `sync_in` and `valid_in` high starts the capture, and that frame is the one stored.
- R6: `done` rises on the edge that writes the last channel. In the wide layout this is the edge of the frame's last valid cycle. In the serial layout it is the edge of the 2048th valid cycle counted from the sync. `done` stays high until an arm, and an arm clears it.
- R7: While `done` is high, new frames do not change the memory contents.
- R8: Cycles with `valid_in` low pause the capture and the delay lines. Gaps inside frames do not change the stored image.
- R9: A valid sync during a capture at a frame position other than 0 aborts the capture, sets `err`, and makes the block wait for the next sync. `err` stays set until an arm that is given outside a capture.
- R10: A host read of the address being written in the same cycle returns the contents from before that write.
- R11: In the serial layout, syncs of the following frames that fall on frame position 0 during a capture neither abort it nor set `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | Single-cycle request to capture the next frame; clears `done` and `err` |
| sync_in | input | 1 | Frame start marker, qualified by `valid_in` |
| valid_in | input | 1 | Lane words are present this cycle |
| lanes_in | input | LANES*LANE_W (128) | Lane k in bits [32k+31:32k] |
| rd_en | input | 1 | Host read request |
| rd_addr | input | log2(CHANNELS) (11) | Host word address (channel number) |
| rd_data | output | LANE_W (32) | Read word |
| rd_valid | output | 1 | `rd_data` holds the answer to an earlier request |
| done | output | 1 | A complete spectrum is held |
| err | output | 1 | Sticky: a capture was aborted by a misplaced sync |

## Verification
Two functions can fall in the same cycle: a capture write and a host read of the same address. The bench triggers this by issuing a read of address 800 in the exact input cycle in which both layouts write channel 800 of a second capture. In the serial layout that is lane 0 at cycle 200, and in the wide layout it is row 200. The scoreboard expects the first capture's word there, and the later full readback must show the new word. A second overlap is a sync arriving while the serial layout is still draining earlier lanes. Syncs on frame boundaries must pass silently, while a sync injected at position 100 must abort the capture.

// File: rtl/spec_cap_pkg.sv
`timescale 1ns/1ps
// Shared types for the spectrum capture buffer.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package spec_cap_pkg;

    // Capture controller states
    typedef enum logic [1:0] {
        CAP_IDLE  = 2'd0,
        CAP_ARMED = 2'd1,
        CAP_RUN   = 2'd2,
        CAP_DONE  = 2'd3
    } cap_state_t;

endpackage

// File: rtl/lane_delay_stage.sv
`timescale 1ns/1ps
// One ring-buffer delay stage: DEPTH advances of delay.
// What it does: on each advance it returns the word written DEPTH advances
// earlier (read before write at the same slot) and stores the new word.
// Assumes: the caller supplies a pointer that steps by one per advance and
// wraps at DEPTH. The storage has no reset; contents before the first DEPTH
// advances are don't-care.
module lane_delay_stage #(
    parameter int W     = 32,
    parameter int DEPTH = 512,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          adv,
    input  logic [PW-1:0] ptr,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout
);

    logic [W-1:0] ring [DEPTH];

    // Oldest word sits at the slot about to be overwritten
    assign dout = ring[ptr];

    // Store the incoming word on each advance
    always_ff @(posedge clk) begin
        if (adv) begin
            ring[ptr] <= din;
        end
    end

endmodule

// File: rtl/spec_ram.sv
`timescale 1ns/1ps
// Simple dual-port memory with a host read pipeline.
// What it does: one write port, one synchronous read port. A read issued on
// cycle n shows its data and a valid flag after 1+PIPE edges. A small tag
// travels with the read so the caller can pick a slice of a wide row.
// Assumes: read and write may hit the same address in one cycle; the read
// then returns the old word.
module spec_ram #(
    parameter int DW    = 32,
    parameter int DEPTH = 2048,
    parameter int PIPE  = 0,
    parameter int TAGW  = 1,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [DW-1:0]   wdata,
    input  logic            re,
    input  logic [AW-1:0]   raddr,
    input  logic [TAGW-1:0] rtag,
    output logic [DW-1:0]   rdata,
    output logic [TAGW-1:0] rtag_o,
    output logic            rvalid
);

    logic [DW-1:0]   store [DEPTH];
    logic [DW-1:0]   dq [PIPE+1];
    logic [TAGW-1:0] tq [PIPE+1];
    logic            vq [PIPE+1];

    // Write port: capture side
    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    // Read port and data/tag pipeline
    always_ff @(posedge clk) begin
        if (re) begin
            dq[0] <= store[raddr];
            tq[0] <= rtag;
        end
        for (int i = 1; i <= PIPE; i++) begin
            dq[i] <= dq[i-1];
            tq[i] <= tq[i-1];
        end
    end

    // Valid pipeline, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i <= PIPE; i++) begin
                vq[i] <= 1'b0;
            end
        end else begin
            vq[0] <= re;
            for (int i = 1; i <= PIPE; i++) begin
                vq[i] <= vq[i-1];
            end
        end
    end

    assign rdata  = dq[PIPE];
    assign rtag_o = tq[PIPE];
    assign rvalid = vq[PIPE];

endmodule

// File: rtl/capture_ctrl.sv
`timescale 1ns/1ps
// Capture sequencer: arm, start on sync, count writes, done, abort.
// What it does: after an arm, the next valid sync starts a run. Each valid
// cycle of the run issues one write at the current count. The run ends with
// done after LAST+1 writes. A valid sync whose frame position (low POS_W
// count bits) is non-zero aborts the run and sets a sticky error.
// Assumes: sync is only meaningful together with valid. An arm during a run
// is ignored.
module capture_ctrl
    import spec_cap_pkg::*;
#(
    parameter int CNT_W = 11,
    parameter int POS_W = 9,
    parameter int LAST  = 2047
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             sync,
    input  logic             valid,
    output logic             wr_en,
    output logic [CNT_W-1:0] cnt,
    output logic             done,
    output logic             err,
    output logic             capturing,
    output logic             armed
);

    cap_state_t st;
    logic       pos_nz;
    logic       at_last;

    assign pos_nz  = |cnt[POS_W-1:0];
    assign at_last = (cnt == CNT_W'(LAST));

    // Write strobe for the current cycle
    always_comb begin
        wr_en = 1'b0;
        if (valid) begin
            case (st)
                CAP_ARMED: wr_en = sync;
                CAP_RUN:   wr_en = !(sync && pos_nz);
                default:   wr_en = 1'b0;
            endcase
        end
    end

    // State, count and sticky error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= CAP_IDLE;
            cnt <= '0;
            err <= 1'b0;
        end else begin
            case (st)
                CAP_IDLE, CAP_DONE: begin
                    if (arm) begin
                        st  <= CAP_ARMED;
                        cnt <= '0;
                        err <= 1'b0;
                    end
                end
                CAP_ARMED: begin
                    if (arm) begin
                        err <= 1'b0;
                    end
                    if (valid && sync) begin
                        st  <= CAP_RUN;
                        cnt <= CNT_W'(1);
                    end
                end
                CAP_RUN: begin
                    if (valid) begin
                        if (sync && pos_nz) begin
                            st  <= CAP_ARMED;
                            cnt <= '0;
                            err <= 1'b1;
                        end else if (at_last) begin
                            st  <= CAP_DONE;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                end
                default: st <= CAP_IDLE;
            endcase
        end
    end

    assign done      = (st == CAP_DONE);
    assign capturing = (st == CAP_RUN);
    assign armed     = (st == CAP_ARMED);

endmodule

// File: rtl/spectrum_capture_buf.sv
`timescale 1ns/1ps
// Parallel-lane spectrum capture buffer (top).
// What it does: stores one spectrum that arrives as LANES words per valid
// cycle so that host word address N holds channel N. With WIDE_MODE=0 the
// lanes are staggered by k frame lengths through ring delay stages and
// merged into one word per cycle; the store then takes LANES frames of
// valid cycles. With WIDE_MODE=1 each cycle's lanes form one row.
// Assumes: lane k at frame cycle t carries channel LANES*t+k. CHANNELS and
// LANES are powers of two with LANES >= 2. Frames keep arriving so the
// serial layout can drain its delay lines.
module spectrum_capture_buf #(
    parameter int LANES     = 4,
    parameter int LANE_W    = 32,
    parameter int CHANNELS  = 2048,
    parameter bit WIDE_MODE = 1'b0,
    parameter int READ_PIPE = 0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        arm,
    input  logic                        sync_in,
    input  logic                        valid_in,
    input  logic [LANES*LANE_W-1:0]     lanes_in,
    input  logic                        rd_en,
    input  logic [$clog2(CHANNELS)-1:0] rd_addr,
    output logic [LANE_W-1:0]           rd_data,
    output logic                        rd_valid,
    output logic                        done,
    output logic                        err
);

    localparam int CH_AW     = $clog2(CHANNELS);
    localparam int FRAME_CYC = CHANNELS / LANES;
    localparam int POS_W     = $clog2(FRAME_CYC);
    localparam int SELW      = $clog2(LANES);
    localparam int CNT_W     = CH_AW;
    localparam int LAST_CNT  = WIDE_MODE ? FRAME_CYC - 1 : CHANNELS - 1;

    logic             wr_en;
    logic [CNT_W-1:0] cnt;
    logic             capturing;
    logic             armed;

    capture_ctrl #(
        .CNT_W (CNT_W),
        .POS_W (POS_W),
        .LAST  (LAST_CNT)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .sync      (sync_in),
        .valid     (valid_in),
        .wr_en     (wr_en),
        .cnt       (cnt),
        .done      (done),
        .err       (err),
        .capturing (capturing),
        .armed     (armed)
    );

    if (WIDE_MODE) begin : g_wide
        logic [LANES*LANE_W-1:0] row_q;
        logic [SELW-1:0]         sel_q;

        spec_ram #(
            .DW    (LANES*LANE_W),
            .DEPTH (FRAME_CYC),
            .PIPE  (READ_PIPE),
            .TAGW  (SELW)
        ) u_ram (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (wr_en),
            .waddr  (cnt[POS_W-1:0]),
            .wdata  (lanes_in),
            .re     (rd_en),
            .raddr  (rd_addr[CH_AW-1:SELW]),
            .rtag   (rd_addr[SELW-1:0]),
            .rdata  (row_q),
            .rtag_o (sel_q),
            .rvalid (rd_valid)
        );

        // Pick the 32-bit slice named by the low address bits
        assign rd_data = row_q[sel_q*LANE_W +: LANE_W];

    end else begin : g_serial
        logic [LANE_W-1:0] lane_w [LANES];
        logic [LANE_W-1:0] lane_d [LANES];
        logic [POS_W-1:0]  dptr;
        logic [SELW-1:0]   wsel;
        logic [CH_AW-1:0]  waddr;
        logic              unused_tag;
        logic              tag_q;

        for (genvar k = 0; k < LANES; k++) begin : g_unpack
            assign lane_w[k] = lanes_in[k*LANE_W +: LANE_W];
        end

        // Shared ring pointer, one step per valid cycle
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dptr <= '0;
            end else if (valid_in) begin
                dptr <= dptr + POS_W'(1);
            end
        end

        assign lane_d[0] = lane_w[0];

        for (genvar k = 1; k < LANES; k++) begin : g_lane
            logic [LANE_W-1:0] chain [k+1];
            assign chain[0] = lane_w[k];
            for (genvar s = 0; s < k; s++) begin : g_stage
                lane_delay_stage #(
                    .W     (LANE_W),
                    .DEPTH (FRAME_CYC)
                ) u_dly (
                    .clk  (clk),
                    .adv  (valid_in),
                    .ptr  (dptr),
                    .din  (chain[s]),
                    .dout (chain[s+1])
                );
            end
            assign lane_d[k] = chain[k];
        end

        // Lane chosen by the count's high bits; address interleaves lanes
        assign wsel  = cnt[CNT_W-1:POS_W];
        assign waddr = {cnt[POS_W-1:0], wsel};

        spec_ram #(
            .DW    (LANE_W),
            .DEPTH (CHANNELS),
            .PIPE  (READ_PIPE),
            .TAGW  (1)
        ) u_ram (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (wr_en),
            .waddr  (waddr),
            .wdata  (lane_d[wsel]),
            .re     (rd_en),
            .raddr  (rd_addr),
            .rtag   (1'b0),
            .rdata  (rd_data),
            .rtag_o (tag_q),
            .rvalid (rd_valid)
        );

        assign unused_tag = tag_q;
    end

endmodule

// File: rtl/spectrum_capture_chk.sv
`timescale 1ns/1ps
// Assertion checker for spectrum_capture_buf, attached by bind.
// What it does: checks the read latency, the start, abort, done and
// write-blocking rules over time.
// Assumes: LAT is small (one plus the read pipeline depth).
module spectrum_capture_chk #(
    parameter int LAT   = 1,
    parameter int CNT_W = 11,
    parameter int POS_W = 9,
    parameter int LAST  = 2047
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arm,
    input logic             sync_in,
    input logic             valid_in,
    input logic             rd_en,
    input logic             rd_valid,
    input logic             done,
    input logic             err,
    input logic             wr_en,
    input logic [CNT_W-1:0] cnt,
    input logic             capturing,
    input logic             armed
);

    logic [LAT-1:0] rd_sh;

    // Independent record of outstanding reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_sh <= '0;
        end else begin
            rd_sh <= (rd_sh << 1) | LAT'(rd_en);
        end
    end

    p_rd_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid == rd_sh[LAT-1]);

    p_start_on_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
        armed && valid_in && sync_in |-> wr_en);

    p_done_on_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        capturing && wr_en && (cnt == CNT_W'(LAST)) |=> done);

    p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done && !arm |=> done);

    p_no_write_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !wr_en);

    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        capturing && valid_in && sync_in && (cnt[POS_W-1:0] != '0)
        |=> err && armed);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err && !arm |=> err);

    p_boundary_sync_r11: assert property (@(posedge clk) disable iff (!rst_n)
        capturing && valid_in && sync_in && (cnt[POS_W-1:0] == '0) |-> wr_en);

endmodule

bind spectrum_capture_buf spectrum_capture_chk #(
    .LAT   (READ_PIPE + 1),
    .CNT_W (CNT_W),
    .POS_W (POS_W),
    .LAST  (LAST_CNT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .sync_in   (sync_in),
    .valid_in  (valid_in),
    .rd_en     (rd_en),
    .rd_valid  (rd_valid),
    .done      (done),
    .err       (err),
    .wr_en     (wr_en),
    .cnt       (cnt),
    .capturing (capturing),
    .armed     (armed)
);

// File: tb/tb_spectrum_capture_buf.sv
`timescale 1ns/1ps
// Scoreboard bench: serial layout (dut, latency 1) and wide layout
// (dut_wide, latency 3) share one stimulus stream.
module tb_spectrum_capture_buf;

    localparam int NL  = 4;
    localparam int LW  = 32;
    localparam int NCH = 2048;
    localparam int FC  = NCH / NL;
    localparam int AW  = 11;
    localparam int LAT_S = 1;
    localparam int LAT_W = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           arm = 1'b0;
    logic           sync_in = 1'b0;
    logic           valid_in = 1'b0;
    logic [NL*LW-1:0] lanes_in = '0;
    logic           rd_en = 1'b0;
    logic [AW-1:0]  rd_addr = '0;
    logic [LW-1:0]  rd_data_s, rd_data_w;
    logic           rd_valid_s, rd_valid_w;
    logic           done_s, done_w, err_s, err_w;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    typedef struct {
        logic [LW-1:0] exp;
        int            issue;
        string         req;
    } rd_item_t;

    rd_item_t q_s[$];
    rd_item_t q_w[$];

    spectrum_capture_buf #(.WIDE_MODE(1'b0), .READ_PIPE(0)) dut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .sync_in(sync_in),
        .valid_in(valid_in), .lanes_in(lanes_in), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data_s), .rd_valid(rd_valid_s),
        .done(done_s), .err(err_s));

    spectrum_capture_buf #(.WIDE_MODE(1'b1), .READ_PIPE(2)) dut_wide (
        .clk(clk), .rst_n(rst_n), .arm(arm), .sync_in(sync_in),
        .valid_in(valid_in), .lanes_in(lanes_in), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data_w), .rd_valid(rd_valid_w),
        .done(done_w), .err(err_w));

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Channel value: frame id in the top byte, channel number at the bottom
    function automatic logic [LW-1:0] chv(int f, int ch);
        return {8'(f), 8'hC3, 5'd0, 11'(ch)};
    endfunction

    task automatic check(bit ok, string req, string what, logic [LW-1:0] act, logic [LW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // Driver: one frame, optional idle gaps, optional misplaced sync
    task automatic send_frame(int f, bit gaps, int bad_t);
        for (int t = 0; t < FC; t++) begin
            if (gaps && (t % 5 == 4)) begin
                @(posedge clk); #1;
                valid_in = 1'b0;
                sync_in  = 1'b0;
            end
            @(posedge clk); #1;
            valid_in = 1'b1;
            sync_in  = (t == 0) || (t == bad_t);
            for (int k = 0; k < NL; k++) begin
                lanes_in[k*LW +: LW] = chv(f, NL*t + k);
            end
        end
        @(posedge clk); #1;
        valid_in = 1'b0;
        sync_in  = 1'b0;
    endtask

    task automatic pulse_arm();
        @(posedge clk); #1;
        arm = 1'b1;
        @(posedge clk); #1;
        arm = 1'b0;
    endtask

    // Driver: read a range and push the expected words
    task automatic read_range(int start, int n, int fs, int fw, string req_s, string req_w);
        rd_item_t it;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            rd_en   = 1'b1;
            rd_addr = AW'(start + i);
            it.issue = cyc;
            it.exp = chv(fs, start + i); it.req = req_s; q_s.push_back(it);
            it.exp = chv(fw, start + i); it.req = req_w; q_w.push_back(it);
        end
        @(posedge clk); #1;
        rd_en = 1'b0;
        repeat (6) @(posedge clk);
        #1;
        check(q_s.size() == 0, "R4", "serial reads left", LW'(q_s.size()), 0);
        check(q_w.size() == 0, "R4", "wide reads left", LW'(q_w.size()), 0);
    endtask

    // Monitor: serial layout
    always @(negedge clk) begin
        rd_item_t it;
        if (rst_n && rd_valid_s) begin
            if (q_s.size() == 0) begin
                check(1'b0, "R4", "serial unexpected valid", rd_data_s, 0);
            end else begin
                it = q_s.pop_front();
                check(rd_data_s == it.exp, it.req, "serial data", rd_data_s, it.exp);
                check(cyc - it.issue == LAT_S, "R4", "serial latency", LW'(cyc - it.issue), LAT_S);
            end
        end
    end

    // Monitor: wide layout
    always @(negedge clk) begin
        rd_item_t it;
        if (rst_n && rd_valid_w) begin
            if (q_w.size() == 0) begin
                check(1'b0, "R4", "wide unexpected valid", rd_data_w, 0);
            end else begin
                it = q_w.pop_front();
                check(rd_data_w == it.exp, it.req, "wide data", rd_data_w, it.exp);
                check(cyc - it.issue == LAT_W, "R4", "wide latency", LW'(cyc - it.issue), LAT_W);
            end
        end
    end

    // Watchdog
    initial begin
        #(4 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        rd_item_t it;
        repeat (4) @(posedge clk);
        #1;
        // R1 reset state
        check(done_s == 0 && err_s == 0 && rd_valid_s == 0, "R1", "serial reset", {done_s, err_s, rd_valid_s}, 0);
        check(done_w == 0 && err_w == 0 && rd_valid_w == 0, "R1", "wide reset", {done_w, err_w, rd_valid_w}, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;

        // Capture 1: frame 1
        pulse_arm();
        send_frame(1, 1'b0, -1);
        check(done_w == 1, "R6", "wide done after one frame", done_w, 1);
        check(done_s == 0, "R6", "serial not done after one frame", done_s, 0);
        send_frame(2, 1'b0, -1);
        send_frame(3, 1'b0, -1);
        check(done_s == 0, "R6", "serial not done after three frames", done_s, 0);
        send_frame(4, 1'b0, -1);
        check(done_s == 1, "R6", "serial done after four frames", done_s, 1);
        check(err_s == 0, "R11", "boundary syncs no error", err_s, 0);
        check(err_w == 0, "R11", "wide no error", err_w, 0);
        read_range(0, NCH, 1, 1, "R2", "R3");

        // Capture 2: frame 5, with a read colliding with a write (R10)
        pulse_arm();
        check(done_s == 0 && done_w == 0, "R6", "arm clears done", {done_s, done_w}, 0);
        fork
            send_frame(5, 1'b0, -1);
            begin
                repeat (201) @(posedge clk);
                #1;
                rd_en   = 1'b1;
                rd_addr = AW'(800);
                it.issue = cyc;
                it.exp = chv(1, 800); it.req = "R10";
                q_s.push_back(it);
                q_w.push_back(it);
                @(posedge clk); #1;
                rd_en = 1'b0;
            end
        join
        send_frame(6, 1'b0, -1);
        send_frame(7, 1'b0, -1);
        send_frame(8, 1'b0, -1);
        check(done_s == 1 && done_w == 1, "R5", "capture 2 done", {done_s, done_w}, 2'b11);
        read_range(0, NCH, 5, 5, "R5", "R5");

        // Capture 3: abort by misplaced sync, then gapped frames
        pulse_arm();
        send_frame(9, 1'b0, 100);
        check(err_s == 1, "R9", "serial abort sets err", err_s, 1);
        check(err_w == 1, "R9", "wide abort sets err", err_w, 1);
        check(done_s == 0 && done_w == 0, "R9", "abort no done", {done_s, done_w}, 0);
        send_frame(10, 1'b1, -1);
        check(done_w == 1, "R8", "wide done with gaps", done_w, 1);
        check(err_w == 1, "R9", "wide err sticky", err_w, 1);
        send_frame(11, 1'b1, -1);
        send_frame(12, 1'b1, -1);
        check(done_s == 0, "R8", "serial paused by gaps", done_s, 0);
        send_frame(13, 1'b1, -1);
        check(done_s == 1, "R8", "serial done with gaps", done_s, 1);
        check(err_s == 1, "R9", "serial err sticky", err_s, 1);
        send_frame(14, 1'b0, -1);
        check(done_s == 1 && done_w == 1, "R7", "done held without arm", {done_s, done_w}, 2'b11);
        read_range(0, NCH, 10, 10, "R8", "R7");

        // Re-arm clears err and done
        pulse_arm();
        check(err_s == 0 && err_w == 0, "R9", "arm clears err", {err_s, err_w}, 0);
        check(done_s == 0 && done_w == 0, "R6", "arm clears done again", {done_s, done_w}, 0);

        finish_run();
    end

endmodule